// File: doc/BRIEF.md
# SPI Slave Port with Select Synchronization

This block is the receiving end of an SPI link. An external master supplies the serial clock, and the block never generates one. The serial clock, the select line and the serial input are brought into the system clock domain through a short flop chain. Every bit is shifted on an edge detected in that domain, so the system clock must run at least four times faster than the serial clock. Each byte moves most significant bit first. Local logic loads a transmit buffer and reads a receive buffer. A one-cycle pulse marks the end of each byte. Two sticky flags record a transmit write that arrived too late and a received byte that found the buffer still full.

A 4-bit mode word picks the operating mode. In select-gated mode, shifting and output drive happen only while the active-low select is low. When select rises, the block abandons any partial byte. In free-running mode the select pin is ignored. Two further settings choose the idle level of the serial clock and the edge on which output data changes. A receive-only switch keeps the serial output released at all times, so the input can share a wire with it.

Top module: `spis_port`

## Requirements
- R1: After reset `rx_full`, `wcol`, `ovf` and `byte_done` are 0. With `en` = 0, `sdo_oe` is 0.
- R2: After the eighth sampled bit, `rx_data` holds the first bit received in bit 7 and the last in bit 0. `rx_full` becomes 1, and `byte_done` pulses for exactly one cycle.
- R3: `sdo` presents the transmit buffer most significant bit first: bit 7 during the first bit period and bit 0 during the eighth.
- R4: `cpol` is the idle level of `sck`, and the leading edge is the change away from idle. With `early_out` = 0, output data changes on the leading edge and input is sampled on the trailing edge. With `early_out` = 1, bit 7 appears once select falls, output changes on the trailing edge, and input is sampled on the leading edge.
- R5: `mode` = 4'b0100 selects select-gated slave mode and `mode` = 4'b0101 selects free-running slave mode. Any other code, or `en` = 0, makes the block inactive. An inactive block drives no output and receives no bytes. In select-gated mode, clocking while `ss_n` is high receives nothing.
- R6: In select-gated mode, `sdo_oe` is 0 as soon as `ss_n` is high, with no clock edge needed, even in the middle of a byte. The bit counter returns to zero, so the partial byte is discarded and the next byte starts at bit 7.
- R7: Clearing `en` also returns the bit counter to zero. After `en` is set again, a full byte is received and sent correctly.
- R8: With `early_out` = 1, select gating is required. `mode` = 4'b0101 together with `early_out` = 1 leaves the block inactive.
- R9: With `rx_only` = 1, `sdo_oe` stays 0 while reception continues normally.
- R10: A `tx_wr` pulse while a byte is in progress is ignored and sets `wcol`. A byte is in progress from the cycle its first output bit is loaded until its last bit is sampled.
- R11: A byte that completes while `rx_full` is 1 and no read occurs in that cycle sets `ovf`. It leaves `rx_data` unchanged.
- R12: A `rx_rd` pulse clears `rx_full`. An `err_clr` pulse clears `wcol` and `ovf`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Port enable; low resets the bit counter |
| mode | input | 4 | Mode code: 4'b0100 select-gated, 4'b0101 free-running |
| cpol | input | 1 | Idle level of the serial clock |
| early_out | input | 1 | 1: first bit shown on select fall, change on trailing edge |
| rx_only | input | 1 | Keep serial output released |
| sck | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Active-low select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for sdo; 0 means released |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_data | input | 8 | Byte to transmit |
| rx_rd | input | 1 | Read strobe; clears rx_full |
| err_clr | input | 1 | Clears wcol and ovf |
| rx_data | output | 8 | Last received byte |
| rx_full | output | 1 | Received byte not yet read |
| byte_done | output | 1 | One-cycle pulse at byte completion |
| wcol | output | 1 | Sticky write-collision flag |
| ovf | output | 1 | Sticky receive-overflow flag |

## Verification
The bench builds the port with the defaults: an 8-bit word and a two-flop synchronizer. It clocks the serial side with a half-period of six system clocks, which leaves a margin over the synchronizer latency on every edge. At that size every combination of clock polarity, output edge and select mode can be swept with several bytes each, and each received and returned byte is compared against the value the bench drove. Short directed runs then cover the cases that end or spoil a byte: select rising after four bits, enable dropping after three bits, a late write, a second byte arriving before a read, the illegal free-running and early-output pairing, and receive-only operation.

// File: rtl/spis_pkg.sv
package spis_pkg;

    localparam logic [3:0] MODE_SLV_SEL  = 4'b0100;
    localparam logic [3:0] MODE_SLV_FREE = 4'b0101;

    typedef struct packed {
        logic active;
        logic use_sel;
        logic early_out;
        logic cpol;
        logic rx_only;
    } cfg_t;

    typedef struct packed {
        logic sample;
        logic shift;
    } edges_t;

    function automatic cfg_t decode_cfg(input logic en, input logic [3:0] mode,
                                        input logic cpol, input logic early_out,
                                        input logic rx_only);
        cfg_t c;
        c.use_sel   = (mode == MODE_SLV_SEL);
        c.active    = en && (c.use_sel || ((mode == MODE_SLV_FREE) && !early_out));
        c.early_out = early_out;
        c.cpol      = cpol;
        c.rx_only   = rx_only;
        return c;
    endfunction

    function automatic edges_t classify_edges(input logic rise, input logic fall,
                                              input logic cpol, input logic early_out);
        edges_t e;
        logic lead;
        logic trail;
        lead     = cpol ? fall : rise;
        trail    = cpol ? rise : fall;
        e.sample = early_out ? lead : trail;
        e.shift  = early_out ? trail : lead;
        return e;
    endfunction

endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
    parameter int N = 3,
    parameter int STAGES = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_q
);
    logic [N-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
        end else begin
            chain[0] <= async_in;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign sync_q = chain[STAGES-1];
endmodule

// File: rtl/spis_shifter.sv
module spis_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         sample,
    input  logic         shift,
    input  logic         prime,
    input  logic         sdi_s,
    input  logic [W-1:0] tx_word,
    output logic         out_bit,
    output logic [W-1:0] rx_word,
    output logic         done,
    output logic         busy
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] cnt;
    logic [W-1:0]  in_sr;
    logic [W-1:0]  out_sr;
    logic          load_pend;
    logic          in_byte;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            in_sr     <= '0;
            out_sr    <= '0;
            load_pend <= 1'b1;
            in_byte   <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!run) begin
                cnt       <= '0;
                in_byte   <= 1'b0;
                load_pend <= 1'b1;
            end else begin
                if (prime) begin
                    out_sr    <= tx_word;
                    in_byte   <= 1'b1;
                    load_pend <= 1'b0;
                end else if (shift) begin
                    if (load_pend) begin
                        out_sr    <= tx_word;
                        in_byte   <= 1'b1;
                        load_pend <= 1'b0;
                    end else begin
                        out_sr <= out_sr << 1;
                    end
                end
                if (sample) begin
                    in_sr <= {in_sr[W-2:0], sdi_s};
                    if (cnt == LAST) begin
                        cnt       <= '0;
                        done_q    <= 1'b1;
                        in_byte   <= 1'b0;
                        load_pend <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end

    assign out_bit = out_sr[W-1];
    assign rx_word = in_sr;
    assign done    = done_q;
    assign busy    = in_byte;

    // R6 / R7: losing select or enable clears the bit counter
    assert_cnt_clear_R6: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));

    // R2: a completed byte leaves the counter at zero for the next one
    assert_done_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (cnt == '0) && !in_byte);
endmodule

// File: rtl/spis_bufs.sv
module spis_bufs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tx_wr,
    input  logic [W-1:0] tx_data,
    input  logic         busy,
    input  logic         done,
    input  logic [W-1:0] rx_word,
    input  logic         rx_rd,
    input  logic         err_clr,
    output logic [W-1:0] tx_word,
    output logic [W-1:0] rx_data,
    output logic         rx_full,
    output logic         wcol,
    output logic         ovf
);
    logic [W-1:0] tx_q;
    logic [W-1:0] rx_q;
    logic         full_q;
    logic         wcol_q;
    logic         ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q   <= '0;
            rx_q   <= '0;
            full_q <= 1'b0;
            wcol_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            if (err_clr) begin
                wcol_q <= 1'b0;
                ovf_q  <= 1'b0;
            end
            if (tx_wr) begin
                if (busy) wcol_q <= 1'b1;
                else      tx_q   <= tx_data;
            end
            if (rx_rd) full_q <= 1'b0;
            if (done) begin
                if (full_q && !rx_rd) begin
                    ovf_q <= 1'b1;
                end else begin
                    rx_q   <= rx_word;
                    full_q <= 1'b1;
                end
            end
        end
    end

    assign tx_word = tx_q;
    assign rx_data = rx_q;
    assign rx_full = full_q;
    assign wcol    = wcol_q;
    assign ovf     = ovf_q;

    // R10: a late write leaves the buffer alone and raises the flag
    assert_wcol_keep_R10: assert property (@(posedge clk) disable iff (rst)
        (tx_wr && busy) |=> (wcol_q && $stable(tx_q)));

    // R11: an unread byte is not overwritten
    assert_no_overwrite_R11: assert property (@(posedge clk) disable iff (rst)
        (done && full_q && !rx_rd) |=> (ovf_q && $stable(rx_q)));

    // R2: a completion into a free buffer marks it full
    assert_fill_R2: assert property (@(posedge clk) disable iff (rst)
        (done && !(full_q && !rx_rd)) |=> full_q);
endmodule

// File: rtl/spis_port.sv
module spis_port
    import spis_pkg::*;
#(
    parameter int W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [3:0]   mode,
    input  logic         cpol,
    input  logic         early_out,
    input  logic         rx_only,
    input  logic         sck,
    input  logic         ss_n,
    input  logic         sdi,
    output logic         sdo,
    output logic         sdo_oe,
    input  logic         tx_wr,
    input  logic [W-1:0] tx_data,
    input  logic         rx_rd,
    input  logic         err_clr,
    output logic [W-1:0] rx_data,
    output logic         rx_full,
    output logic         byte_done,
    output logic         wcol,
    output logic         ovf
);
    cfg_t   cfg;
    edges_t edg;
    logic [2:0]   pins_s;
    logic         sck_s, ss_s, sdi_s;
    logic         sck_d, ss_d;
    logic         selected, run, prime;
    logic         busy, done;
    logic [W-1:0] tx_word, rx_word;

    assign cfg = decode_cfg(en, mode, cpol, early_out, rx_only);

    spis_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({sdi, ss_n, sck}),
        .sync_q   (pins_s)
    );

    assign sck_s = pins_s[0];
    assign ss_s  = pins_s[1];
    assign sdi_s = pins_s[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d <= 1'b0;
            ss_d  <= 1'b1;
        end else begin
            sck_d <= sck_s;
            ss_d  <= ss_s;
        end
    end

    assign edg      = classify_edges(sck_s & ~sck_d, ~sck_s & sck_d, cfg.cpol, cfg.early_out);
    assign selected = cfg.use_sel ? ~ss_s : 1'b1;
    assign run      = cfg.active & selected;
    assign prime    = run & cfg.use_sel & cfg.early_out & ss_d & ~ss_s;

    spis_shifter #(.W(W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .sample  (edg.sample),
        .shift   (edg.shift),
        .prime   (prime),
        .sdi_s   (sdi_s),
        .tx_word (tx_word),
        .out_bit (sdo),
        .rx_word (rx_word),
        .done    (done),
        .busy    (busy)
    );

    spis_bufs #(.W(W)) u_bufs (
        .clk     (clk),
        .rst     (rst),
        .tx_wr   (tx_wr),
        .tx_data (tx_data),
        .busy    (busy),
        .done    (done),
        .rx_word (rx_word),
        .rx_rd   (rx_rd),
        .err_clr (err_clr),
        .tx_word (tx_word),
        .rx_data (rx_data),
        .rx_full (rx_full),
        .wcol    (wcol),
        .ovf     (ovf)
    );

    // Release uses the raw select pin so it does not wait for the synchronizer
    assign sdo_oe    = cfg.active & ~cfg.rx_only & (cfg.use_sel ? ~ss_n : 1'b1);
    assign byte_done = done;

    // R6: a high select never leaves the output driven
    assert_release_R6: assert property (@(posedge clk) disable iff (rst)
        ((mode == MODE_SLV_SEL) && ss_n) |-> !sdo_oe);

    // R9: receive-only keeps the output released
    assert_rx_only_R9: assert property (@(posedge clk) disable iff (rst)
        rx_only |-> !sdo_oe);

    // R8: early output without select gating is not a legal mode
    assert_illegal_idle_R8: assert property (@(posedge clk) disable iff (rst)
        ((mode == MODE_SLV_FREE) && early_out) |-> !sdo_oe);
endmodule

// File: tb/spis_port_tb.sv
module spis_port_tb;
    localparam int H = 6;
    localparam logic [3:0] M_SEL  = 4'b0100;
    localparam logic [3:0] M_FREE = 4'b0101;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic [3:0] mode = 4'b0000;
    logic cp_g = 1'b0, eo_g = 1'b0, rxo = 1'b0;
    logic sck = 1'b0, ss_n = 1'b1, sdi = 1'b0;
    logic sdo, sdo_oe;
    logic tx_wr = 1'b0, rx_rd = 1'b0, err_clr = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic [7:0] rx_data;
    logic rx_full, byte_done, wcol, ovf;

    int total = 0;
    int bad = 0;
    int done_cnt = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    spis_port u_dut (
        .clk(clk), .rst(rst), .en(en), .mode(mode), .cpol(cp_g), .early_out(eo_g),
        .rx_only(rxo), .sck(sck), .ss_n(ss_n), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
        .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .err_clr(err_clr),
        .rx_data(rx_data), .rx_full(rx_full), .byte_done(byte_done), .wcol(wcol), .ovf(ovf)
    );

    always @(posedge clk) if (byte_done) done_cnt <= done_cnt + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic configure(input logic [3:0] m, input logic cp, input logic eo, input logic ro);
        en = 1'b0; wait_n(1);
        mode = m; cp_g = cp; eo_g = eo; rxo = ro; sck = cp; ss_n = 1'b1;
        wait_n(6);
        en = 1'b1; wait_n(6);
    endtask

    task automatic wr(input logic [7:0] d);
        tx_data = d; tx_wr = 1'b1; wait_n(1); tx_wr = 1'b0;
    endtask

    task automatic rd();
        rx_rd = 1'b1; wait_n(1); rx_rd = 1'b0;
    endtask

    task automatic clr();
        err_clr = 1'b1; wait_n(1); err_clr = 1'b0;
    endtask

    task automatic sel_low();
        ss_n = 1'b0; wait_n(H);
    endtask

    task automatic sel_high();
        ss_n = 1'b1; wait_n(H);
    endtask

    // Master model: drives bits first..first-nbits+1 of m, returns bits seen on sdo
    task automatic run_bits(input logic [7:0] m, input int first, input int nbits,
                            output logic [7:0] s);
        s = 8'h00;
        for (int i = first; i > first - nbits; i--) begin
            if (eo_g) begin
                sdi = m[i];
                wait_n(H);
                s[i] = sdo;
                sck = ~cp_g;
                wait_n(H);
                sck = cp_g;
            end else begin
                sck = ~cp_g;
                sdi = m[i];
                wait_n(H);
                s[i] = sdo;
                sck = cp_g;
                wait_n(H);
            end
        end
        if (eo_g) wait_n(H);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] m, t, s, s2;
        int d0;
        wait_n(4);
        rst = 1'b0;
        wait_n(2);
        // R1 reset state
        chk("R1 rx_full", 32'(rx_full), 0);
        chk("R1 wcol", 32'(wcol), 0);
        chk("R1 ovf", 32'(ovf), 0);
        chk("R1 byte_done", 32'(byte_done), 0);
        chk("R1 sdo_oe", 32'(sdo_oe), 0);

        // Sweep: polarity x output edge x select mode (R2 R3 R4 R5)
        for (int c = 0; c < 8; c++) begin
            logic cp, e, sl;
            cp = c[0]; e = c[1]; sl = c[2];
            if (e && !sl) continue;
            configure(sl ? M_SEL : M_FREE, cp, e, 1'b0);
            for (int k = 0; k < 4; k++) begin
                m = 8'((c * 37 + k * 91 + 5) ^ 8'h5A);
                t = 8'((c * 53 + k * 29) ^ 8'hC3);
                wr(t);
                d0 = done_cnt;
                if (sl) sel_low();
                run_bits(m, 7, 8, s);
                chk("R5 sdo_oe driven", 32'(sdo_oe), 1);
                wait_n(4);
                chk("R2 rx_full", 32'(rx_full), 1);
                chk("R2 R4 rx_data", 32'(rx_data), 32'(m));
                chk("R3 R4 sdo byte", 32'(s), 32'(t));
                chk("R2 one byte_done", 32'(done_cnt - d0), 1);
                if (sl) begin
                    sel_high();
                    chk("R6 released", 32'(sdo_oe), 0);
                end
                rd();
                chk("R12 rx_full cleared", 32'(rx_full), 0);
            end
        end

        // R6: select rises mid-byte
        configure(M_SEL, 1'b0, 1'b0, 1'b0);
        wr(8'h96);
        sel_low();
        run_bits(8'hF0, 7, 4, s);
        ss_n = 1'b1;
        #1;
        chk("R6 immediate release", 32'(sdo_oe), 0);
        wait_n(H);
        chk("R6 partial discarded", 32'(rx_full), 0);
        d0 = done_cnt;
        wr(8'h3C);
        sel_low();
        run_bits(8'h6B, 7, 8, s);
        wait_n(4);
        chk("R6 restart rx", 32'(rx_data), 32'h6B);
        chk("R6 restart tx", 32'(s), 32'h3C);
        chk("R6 one byte_done", 32'(done_cnt - d0), 1);
        sel_high();
        rd();

        // R7: enable drop mid-byte in free-running mode
        configure(M_FREE, 1'b1, 1'b0, 1'b0);
        wr(8'h11);
        run_bits(8'hAA, 7, 3, s);
        en = 1'b0; wait_n(4);
        en = 1'b1; wait_n(4);
        wr(8'h22);
        run_bits(8'h5D, 7, 8, s);
        wait_n(4);
        chk("R7 rx after enable", 32'(rx_data), 32'h5D);
        chk("R7 tx after enable", 32'(s), 32'h22);
        rd();

        // R5: unknown mode code and select held high
        d0 = done_cnt;
        configure(4'b0000, 1'b0, 1'b0, 1'b0);
        run_bits(8'hC7, 7, 8, s);
        wait_n(4);
        chk("R5 bad code no rx", 32'(rx_full), 0);
        chk("R5 bad code no drive", 32'(sdo_oe), 0);
        configure(M_SEL, 1'b0, 1'b0, 1'b0);
        run_bits(8'hC7, 7, 8, s);
        wait_n(4);
        chk("R5 unselected no rx", 32'(rx_full), 0);
        chk("R5 no byte_done", 32'(done_cnt - d0), 0);

        // R8: free-running with early output is inactive
        configure(M_FREE, 1'b0, 1'b1, 1'b0);
        run_bits(8'h81, 7, 8, s);
        wait_n(4);
        chk("R8 no rx", 32'(rx_full), 0);
        chk("R8 no drive", 32'(sdo_oe), 0);

        // R9: receive-only
        configure(M_SEL, 1'b0, 1'b1, 1'b1);
        wr(8'h77);
        sel_low();
        chk("R9 released when selected", 32'(sdo_oe), 0);
        run_bits(8'h4E, 7, 8, s);
        chk("R9 released after byte", 32'(sdo_oe), 0);
        wait_n(4);
        chk("R9 rx works", 32'(rx_data), 32'h4E);
        sel_high();
        rd();

        // R10: write collision
        configure(M_SEL, 1'b0, 1'b0, 1'b0);
        wr(8'hA1);
        sel_low();
        run_bits(8'h35, 7, 3, s);
        wr(8'h5E);
        chk("R10 wcol set", 32'(wcol), 1);
        run_bits(8'h35, 4, 5, s2);
        wait_n(4);
        chk("R10 tx kept", 32'(s | s2), 32'hA1);
        chk("R10 rx intact", 32'(rx_data), 32'h35);
        sel_high();
        rd();
        sel_low();
        run_bits(8'h00, 7, 8, s);
        wait_n(4);
        chk("R10 buffer unchanged", 32'(s), 32'hA1);
        sel_high();
        rd();
        clr();
        chk("R12 wcol cleared", 32'(wcol), 0);

        // R11: overflow
        configure(M_SEL, 1'b1, 1'b0, 1'b0);
        d0 = done_cnt;
        sel_low();
        run_bits(8'h39, 7, 8, s);
        wait_n(4);
        run_bits(8'hC4, 7, 8, s);
        wait_n(4);
        chk("R11 ovf set", 32'(ovf), 1);
        chk("R11 rx kept", 32'(rx_data), 32'h39);
        chk("R11 still full", 32'(rx_full), 1);
        chk("R11 two byte_done", 32'(done_cnt - d0), 2);
        sel_high();
        clr();
        chk("R12 ovf cleared", 32'(ovf), 0);
        rd();
        chk("R12 read clears", 32'(rx_full), 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule